// File: doc/BRIEF.md
# Slave Window Protection Decoder

This block sits behind a system-bus slave port and decides, for each incoming cycle, whether the address falls into one of two slave windows. One window lives in the 24-bit address space and the other in the 32-bit space. On a hit it produces the offset into local memory. It then answers with an acknowledge, or with a bus error when the cycle runs into the protected region at the bottom of the window.

Each window base is forced down to a multiple of the installed memory size. One 4-bit boundary code sizes the protected region, and the same code serves both windows. A mode bit chooses what the region blocks: writes only, or both reads and writes. Cycles that the local processor makes through its own windows are never blocked. The decision is registered, so the response shows up one clock after the strobe.

Top module: `slave_win_guard`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `hit`, `ack`, `berr` and `local_off` are all zero.
- R2: The outputs answer one cycle after the strobe. When `cyc_stb` was low at the previous rising edge, `hit`, `ack` and `berr` are all zero.
- R3: When `space_a32`=0 the decoder uses only `addr[23:0]` and clears the low `mem_log2` bits of `win24_base`. The cycle hits when 0 <= addr - base < 2^n, with n = min(`win24_size_log2`, 24).
- R4: When `space_a32`=1 the decoder uses all 32 address bits and clears the low `mem_log2` bits of `win32_base`. The cycle hits when 0 <= addr - base < 2^n, with n = min(`win32_size_log2`, 32).
- R5: A strobed address outside the selected window gives `hit`=0, `ack`=0, `berr`=0 and `local_off`=0.
- R6: On a hit, `local_off` = (addr - aligned base) mod 2^`mem_log2`.
- R7: Boundary code c selects the protected size. Code 0 protects nothing. Codes 1..12 protect the lowest 2^(15+c) bytes of the window, which is 64 KB at code 1. Codes 13..15 protect the lowest 128 MB.
- R8: An external hit inside the protected region gets `berr`=1 and `ack`=0 when it is a write (`wr`=1), or when `prot_rw`=1. With `prot_rw`=0, a read in that region is acknowledged.
- R9: A hit with `ext_src`=0 (local cycle) is always acknowledged and never gets a bus error.
- R10: The same boundary code protects the bottom of the 24-bit window and the bottom of the 32-bit window in the same way.
- R11: `ack` and `berr` are never high together, and either one implies `hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_stb | input | 1 | Cycle strobe, one per access |
| ext_src | input | 1 | 1 = cycle comes from the external bus, 0 = local processor |
| space_a32 | input | 1 | 1 = 32-bit address space, 0 = 24-bit |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 32 | Cycle address |
| win24_base | input | 24 | 24-bit window base setting |
| win24_size_log2 | input | 6 | log2 of 24-bit window size |
| win32_base | input | 32 | 32-bit window base setting |
| win32_size_log2 | input | 6 | log2 of 32-bit window size |
| mem_log2 | input | 5 | log2 of installed memory size |
| prot_rw | input | 1 | 1 = protect reads and writes, 0 = protect writes only |
| prot_code | input | 4 | Protected-region boundary code |
| hit | output | 1 | Cycle decoded into a window |
| local_off | output | 32 | Offset into local memory |
| ack | output | 1 | Acknowledge response |
| berr | output | 1 | Bus-error response |

## Verification
Two functions can fall in the same cycle: the window decode that grants a hit, and the protection check that turns that hit into a bus error. The bench provokes this by placing addresses just below and just above the protected limit. It varies the direction, the mode bit and the source flag, at several boundary codes in both windows. A behavioural model in the bench works out the expected hit, offset and response from plain integer arithmetic. Every cycle is compared against it, so each response can be judged as the right choice between acknowledge and bus error, never both.

// File: rtl/slave_win_guard.sv
module slave_win_guard #(
  parameter int AW         = 32,
  parameter int NARROW_W   = 24,
  parameter int GRAIN_LOG2 = 16,
  parameter int TOP_CODE   = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_stb,
  input  logic          ext_src,
  input  logic          space_a32,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [23:0]   win24_base,
  input  logic [5:0]    win24_size_log2,
  input  logic [AW-1:0] win32_base,
  input  logic [5:0]    win32_size_log2,
  input  logic [4:0]    mem_log2,
  input  logic          prot_rw,
  input  logic [3:0]    prot_code,
  output logic          hit,
  output logic [AW-1:0] local_off,
  output logic          ack,
  output logic          berr
);
  localparam int XW = AW + 1;
  localparam logic [5:0] NARROW_CAP = 6'(NARROW_W);
  localparam logic [5:0] WIDE_CAP   = 6'(AW);
  localparam logic [5:0] GRAIN_BASE = 6'(GRAIN_LOG2 - 1);
  localparam logic [5:0] TOP_SHIFT  = 6'(GRAIN_LOG2 - 1 + TOP_CODE);

  logic [AW-1:0] mem_mask, a_eff, base_eff, diff;
  logic [5:0]    szl, pshift;
  logic          borrow, in_win, in_prot, blocked;
  logic [XW-1:0] win_lim, prot_lim;

  assign mem_mask = ~({AW{1'b1}} << mem_log2);

  always_comb begin
    if (space_a32) begin
      a_eff    = addr;
      base_eff = win32_base & ~mem_mask;
      szl      = (win32_size_log2 > WIDE_CAP) ? WIDE_CAP : win32_size_log2;
    end else begin
      a_eff    = {{(AW-NARROW_W){1'b0}}, addr[NARROW_W-1:0]};
      base_eff = {{(AW-NARROW_W){1'b0}}, win24_base} & ~mem_mask;
      szl      = (win24_size_log2 > NARROW_CAP) ? NARROW_CAP : win24_size_log2;
    end
  end

  assign {borrow, diff} = {1'b0, a_eff} - {1'b0, base_eff};
  assign win_lim        = {{(XW-1){1'b0}}, 1'b1} << szl;
  assign in_win         = !borrow && ({1'b0, diff} < win_lim);

  assign pshift   = (prot_code > 4'(TOP_CODE)) ? TOP_SHIFT : GRAIN_BASE + {2'b0, prot_code};
  assign prot_lim = (prot_code == 4'd0) ? '0 : ({{(XW-1){1'b0}}, 1'b1} << pshift);
  assign in_prot  = {1'b0, diff} < prot_lim;
  assign blocked  = ext_src && in_prot && (wr || prot_rw);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit       <= 1'b0;
      ack       <= 1'b0;
      berr      <= 1'b0;
      local_off <= '0;
    end else begin
      hit       <= cyc_stb && in_win;
      ack       <= cyc_stb && in_win && !blocked;
      berr      <= cyc_stb && in_win && blocked;
      local_off <= (cyc_stb && in_win) ? (diff & mem_mask) : '0;
    end
  end

  AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && berr)); // R11
  AST_RESP_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ack || berr) |-> hit); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_stb |=> !(hit || ack || berr)); // R2
  AST_LOCAL_NO_BERR: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && !ext_src) |=> !berr); // R9
  AST_NO_PROT_CODE0: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && prot_code == 4'd0) |=> !berr); // R7
  AST_READ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && !wr && !prot_rw) |=> !berr); // R8
  AST_OFF_IN_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_stb |=> ((local_off & ~$past(mem_mask)) == '0)); // R6
endmodule

// File: tb/slave_win_guard_tb_top.sv
module slave_win_guard_tb_top;
  logic clk = 0, rst_n = 0;
  logic cyc_stb = 0, ext_src = 0, space_a32 = 0, wr = 0, prot_rw = 0;
  logic [31:0] addr = 0, win32_base = 0;
  logic [23:0] win24_base = 0;
  logic [5:0]  win24_size_log2 = 0, win32_size_log2 = 0;
  logic [4:0]  mem_log2 = 0;
  logic [3:0]  prot_code = 0;
  logic hit, ack, berr;
  logic [31:0] local_off;

  int checks = 0, bad = 0;
  logic e_hit = 0, e_ack = 0, e_berr = 0;
  logic [31:0] e_off = 0;
  string e_tag = "R1";

  always #2 clk = ~clk;

  slave_win_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .ext_src(ext_src),
    .space_a32(space_a32), .wr(wr), .addr(addr), .win24_base(win24_base),
    .win24_size_log2(win24_size_log2), .win32_base(win32_base),
    .win32_size_log2(win32_size_log2), .mem_log2(mem_log2), .prot_rw(prot_rw),
    .prot_code(prot_code), .hit(hit), .local_off(local_off), .ack(ack), .berr(berr)
  );

  task automatic model(input string tag);
    longint a, base, diff, lim, plim, mm;
    int n;
    mm = (longint'(1) << mem_log2) - 1;
    if (space_a32) begin
      a = longint'(addr); base = longint'(win32_base) & ~mm;
      n = (win32_size_log2 > 32) ? 32 : int'(win32_size_log2);
    end else begin
      a = longint'(addr[23:0]); base = longint'(win24_base) & ~mm;
      n = (win24_size_log2 > 24) ? 24 : int'(win24_size_log2);
    end
    lim  = longint'(1) << n;
    diff = a - base;
    if (prot_code == 0) plim = 0;
    else if (prot_code > 12) plim = longint'(1) << 27;
    else plim = longint'(1) << (15 + int'(prot_code));
    e_hit  = cyc_stb && diff >= 0 && diff < lim;
    e_berr = e_hit && ext_src && diff < plim && (wr || prot_rw);
    e_ack  = e_hit && !e_berr;
    e_off  = e_hit ? 32'(diff & mm) : 32'd0;
    if (tag != "") e_tag = tag;
    else if (!cyc_stb) e_tag = "R2";
    else if (!e_hit) e_tag = "R5";
    else if (e_berr) e_tag = "R8";
    else e_tag = "R6";
  endtask

  task automatic compare();
    checks++;
    if (hit !== e_hit || ack !== e_ack || berr !== e_berr || local_off !== e_off) begin
      bad++;
      $display("FAIL %s: got hit=%b ack=%b berr=%b off=%h exp hit=%b ack=%b berr=%b off=%h",
               e_tag, hit, ack, berr, local_off, e_hit, e_ack, e_berr, e_off);
    end
  endtask

  task automatic step(input logic stb, input logic ext, input logic a32, input logic w,
                      input logic [31:0] ad, input string tag);
    @(negedge clk);
    compare();
    cyc_stb = stb; ext_src = ext; space_a32 = a32; wr = w; addr = ad;
    model(tag);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: got hung exp finish");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    win24_base = 24'h512345; win24_size_log2 = 6'd22;
    win32_base = 32'h3012_3456; win32_size_log2 = 6'd27;
    mem_log2 = 5'd22; prot_rw = 0; prot_code = 4'd1;
    cyc_stb = 1; ext_src = 1; addr = 32'h0040_0000;
    repeat (3) @(negedge clk);
    e_hit = 0; e_ack = 0; e_berr = 0; e_off = 0; e_tag = "R1";
    compare();
    rst_n = 1; cyc_stb = 0;
    model("R1");
    // R2: idle strobe low
    step(0, 1, 0, 1, 32'h0040_0000, "R2");
    // R3: 24-bit base 512345 aligns to 400000 with 4 MB; upper address bits ignored
    step(1, 1, 0, 0, 32'hAB40_0010, "R3");
    step(1, 1, 0, 0, 32'h007F_FFFF, "R3");
    step(1, 1, 0, 0, 32'h0080_0000, "R5");
    step(1, 1, 0, 0, 32'h003F_FFFF, "R5");
    // R7/R8: code 1 = 64 KB, write blocked, read passes
    step(1, 1, 0, 1, 32'h0040_FFFF, "R8");
    step(1, 1, 0, 0, 32'h0040_FFFF, "R8");
    step(1, 1, 0, 1, 32'h0041_0000, "R7");
    // R9: local write in region passes
    step(1, 0, 0, 1, 32'h0040_0000, "R9");
    // R4: 32-bit window, base aligned to 30000000
    step(1, 1, 1, 0, 32'h37FF_FFFF, "R4");
    step(1, 1, 1, 0, 32'h3800_0000, "R5");
    step(1, 1, 1, 1, 32'h3000_8000, "R10");
    @(negedge clk); prot_rw = 1; prot_code = 4'd13;
    model("R7");
    step(1, 1, 1, 0, 32'h37FF_FFFF, "R7");
    step(1, 1, 0, 0, 32'h0041_0000, "R10");
    step(1, 0, 1, 0, 32'h3000_0000, "R9");
    @(negedge clk); prot_code = 4'd0;
    model("R7");
    step(1, 1, 1, 1, 32'h3000_0000, "R7");
    step(1, 1, 0, 1, 32'h0040_0000, "R7");
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] off;
      logic a32;
      if (i % 50 == 0) begin
        @(negedge clk); compare();
        cyc_stb = 0;
        mem_log2 = 5'(16 + $urandom_range(0, 8));
        win24_base = 24'($urandom); win24_size_log2 = 6'($urandom_range(16, 26));
        win32_base = $urandom; win32_size_log2 = 6'($urandom_range(18, 33));
        prot_code = 4'($urandom); prot_rw = 1'($urandom);
        model("");
      end
      a32 = 1'($urandom);
      off = $urandom & ((32'd1 << $urandom_range(12, 28)) - 1);
      if ($urandom_range(0, 3) == 0) off = -off;
      step(1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 3) != 0), a32, 1'($urandom),
           a32 ? ((win32_base & ~((32'd1 << mem_log2) - 1)) + off)
               : (({8'h00, win24_base} & ~((32'd1 << mem_log2) - 1)) + off) | ($urandom & 32'hFF00_0000),
           "");
    end
    @(negedge clk); compare();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule